// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the serial front-end of a byte-addressed serial storage device. When the front-end has decoded a write instruction and its start address, the block records the start page and the start offset. It then collects each complete data byte into a small page-sized buffer. The offset advances with each byte and wraps inside the page, so the page number never changes.

A chip-select rise can close the sequence. The block starts a commit only when that rise comes after at least one whole byte, lands on a byte boundary, and the protection unit allowed the address when the instruction arrived. During a commit, the block walks the buffer and writes each byte that was loaded to the storage array. It holds a busy flag for a fixed, parameterised number of clocks, and the status read-out shows this flag as the ready/busy bit. While busy is high, the block refuses further write traffic and holds off standby even when the chip select is high.

Top module: `page_write_seq`

## Requirements
- R1: After a write instruction with start address A and bytes d0..dn, a valid commit writes each byte to array address {A[ADDR_W-1:6], (A[5:0]+i) mod 64}.
- R2: The offset wraps from 63 to 0 inside the same page, and the upper address bits stay fixed. When more than 64 bytes arrive, a later byte replaces the earlier one at the same offset.
- R3: A chip-select rise starts a commit only if at least one whole byte was received and `cs_aligned` is 1. In every other case the sequence is dropped, busy stays 0 and the array is untouched.
- R4: `busy` rises on the clock after the qualifying `cs_rise` and stays high for exactly CYCLE_CLKS cycles.
- R5: `standby` is a registered copy of (`cs_high` and not busy-after-this-edge). It is never 1 while `busy` is 1.
- R6: A write whose `write_permit` was 0 when `cmd_write` was accepted is discarded: no busy interval and no array write.
- R7: While `busy` is 1, `cmd_write`, `data_strobe` and `cs_rise` have no effect.
- R8: `arr_we` is asserted only while `busy` is 1. It writes only the offsets loaded in this sequence, and array bytes that were not loaded keep their value.
- R9: During reset, `busy`, `standby` and `arr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_write | input | 1 | Write instruction and start address decoded (pulse) |
| cmd_addr | input | ADDR_W | Start byte address |
| write_permit | input | 1 | Protection unit allows this address, sampled with cmd_write |
| data_strobe | input | 1 | One complete data byte received (pulse) |
| data_byte | input | 8 | The received data byte |
| cs_high | input | 1 | Chip select is deasserted (level) |
| cs_rise | input | 1 | Chip select just deasserted (pulse) |
| cs_aligned | input | 1 | With cs_rise: no partial byte was pending |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write in progress (ready/busy status) |
| standby | output | 1 | Device may enter standby |

## Verification
The bench builds the block with ADDR_W=10, a 1 KiB array, and CYCLE_CLKS=80. This is just above the 66-cycle minimum that a 64-byte scan needs. With such short busy windows, many commits fit into one run, so a single run reaches the page wrap, overrun of a full page, rejected sequences and traffic during busy. The small array also lets the bench compare every byte against its reference image after each commit.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_BUSY = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pws_page_ram.sv
module pws_page_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pws_cycle_timer.sv
module pws_cycle_timer #(
  parameter int CYCLE_CLKS = 1000000,
  parameter int SCAN_LEN   = 64,
  localparam int CNT_W     = $clog2(CYCLE_CLKS),
  localparam int IW        = $clog2(SCAN_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          run,
  output logic          last,
  output logic          scan_on,
  output logic [IW-1:0] scan_idx
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start && !run) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (last) run <= 1'b0;
      else      cnt <= cnt + 1'b1;
    end
  end

  assign last     = run && (cnt == CNT_W'(CYCLE_CLKS - 1));
  assign scan_on  = run && (cnt < CNT_W'(SCAN_LEN));
  assign scan_idx = cnt[IW-1:0];

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= CNT_W'(CYCLE_CLKS - 1)));
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pws_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 64,
  parameter int CYCLE_CLKS = 1000000,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              write_permit,
  input  logic              data_strobe,
  input  logic [7:0]        data_byte,
  input  logic              cs_high,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              busy,
  output logic              standby
);
  seq_state_t              state, nxt;
  logic [PG_W-1:0]         page_q;
  logic [OFF_W-1:0]        ptr_q;
  logic                    permit_q, got_q;
  logic [PAGE_BYTES-1:0]   valid_q;
  logic                    commit_go, load_new, buf_we;
  logic                    t_run, t_last, t_scan;
  logic [OFF_W-1:0]        t_idx, sidx_q;
  logic                    scan_q;
  logic [7:0]              rd_data;

  assign commit_go = (state == ST_LOAD) && cs_rise && got_q && permit_q && cs_aligned;
  assign load_new  = cmd_write && (state != ST_BUSY) && !((state == ST_LOAD) && cs_rise);
  assign buf_we    = (state == ST_LOAD) && data_strobe && !cs_rise && !cmd_write;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (cmd_write) nxt = ST_LOAD;
      ST_LOAD: begin
        if (cs_rise)        nxt = commit_go ? ST_BUSY : ST_IDLE;
        else if (cmd_write) nxt = ST_LOAD;
      end
      ST_BUSY: if (t_last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      page_q   <= '0;
      ptr_q    <= '0;
      permit_q <= 1'b0;
      got_q    <= 1'b0;
      valid_q  <= '0;
      standby  <= 1'b0;
    end else begin
      state   <= nxt;
      standby <= cs_high && (nxt != ST_BUSY);
      if (load_new) begin
        page_q   <= cmd_addr[ADDR_W-1:OFF_W];
        ptr_q    <= cmd_addr[OFF_W-1:0];
        permit_q <= write_permit;
        got_q    <= 1'b0;
        valid_q  <= '0;
      end else if (buf_we) begin
        ptr_q          <= ptr_q + 1'b1;
        got_q          <= 1'b1;
        valid_q[ptr_q] <= 1'b1;
      end
    end
  end

  assign busy = (state == ST_BUSY);

  pws_page_ram #(.DEPTH(PAGE_BYTES), .DATA_W(8)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (ptr_q),
    .wdata (data_byte),
    .raddr (t_idx),
    .rdata (rd_data)
  );

  pws_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS), .SCAN_LEN(PAGE_BYTES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (commit_go),
    .run      (t_run),
    .last     (t_last),
    .scan_on  (t_scan),
    .scan_idx (t_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q    <= 1'b0;
      sidx_q    <= '0;
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      scan_q    <= t_scan && valid_q[t_idx];
      sidx_q    <= t_idx;
      arr_we    <= scan_q;
      arr_addr  <= {page_q, sidx_q};
      arr_wdata <= rd_data;
    end
  end

  // R8
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_rise));
  // R4
  timer_sync_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> t_run);
  // R5
  stby_excl_chk: assert property (@(posedge clk) disable iff (rst)
    standby |-> !busy);
  // R6
  commit_permit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(permit_q));
  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(page_q));
endmodule

// File: tb/tb_page_write_seq.sv
`timescale 1ns/1ps
module tb_page_write_seq;
  localparam int AW    = 10;
  localparam int PB    = 64;
  localparam int CYC   = 80;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cmd_write = 0, write_permit = 0, data_strobe = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    data_byte = '0;
  logic          cs_high = 1, cs_rise = 0, cs_aligned = 1;
  logic          arr_we, busy, standby;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;

  page_write_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) dut (
    .clk(clk), .rst(rst), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .write_permit(write_permit), .data_strobe(data_strobe), .data_byte(data_byte),
    .cs_high(cs_high), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .busy(busy), .standby(standby)
  );

  logic [7:0] ram     [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  int checks = 0, fails = 0, cyc = 0;

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  initial for (int i = 0; i < DEPTH; i++) ram[i] = init_val(i);
  always @(posedge clk) if (arr_we) ram[arr_addr] <= arr_wdata;

  // behavioural reference
  int         m_state, m_cnt, m_page, m_ptr;
  bit         m_busy, m_perm, m_got, m_stby;
  logic [7:0] m_buf [PB];
  bit         m_val [PB];

  initial for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_val(i);

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_busy = 0; m_cnt = 0; m_stby = 0; m_got = 0; m_perm = 0;
    end else begin
      if (m_busy) begin
        if (m_cnt == CYC - 1) m_busy = 0;
        else m_cnt++;
      end else if (m_state == 1 && cs_rise) begin
        if (m_got && m_perm && cs_aligned) begin
          for (int k = 0; k < PB; k++)
            if (m_val[k]) exp_mem[m_page * PB + k] = m_buf[k];
          m_busy = 1; m_cnt = 0;
        end
        m_state = 0;
      end else if (cmd_write) begin
        m_state = 1; m_page = int'(cmd_addr) / PB; m_ptr = int'(cmd_addr) % PB;
        m_perm = write_permit; m_got = 0;
        for (int k = 0; k < PB; k++) m_val[k] = 0;
      end else if (m_state == 1 && data_strobe) begin
        m_buf[m_ptr] = data_byte; m_val[m_ptr] = 1; m_got = 1;
        m_ptr = (m_ptr + 1) % PB;
      end
      m_stby = cs_high && !m_busy;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) if (!rst) begin
    chk(busy == m_busy, "R4 busy", busy, m_busy);
    chk(standby == m_stby, "R5 standby", standby, m_stby);
    chk(!(arr_we && !m_busy), "R8 write outside busy", arr_we, 0);
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=200000", cyc);
      summary();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic cmd(input int a, input bit p);
    @(negedge clk); cs_high = 0; cmd_write = 1; cmd_addr = AW'(a); write_permit = p;
    @(negedge clk); cmd_write = 0;
  endtask
  task automatic sendb(input logic [7:0] d);
    data_strobe = 1; data_byte = d;
    @(negedge clk); data_strobe = 0;
  endtask
  task automatic csup(input bit al);
    cs_high = 1; cs_rise = 1; cs_aligned = al;
    @(negedge clk); cs_rise = 0; cs_aligned = 1;
  endtask
  task automatic mem_all(input string req);
    int bad = -1;
    for (int i = 0; i < DEPTH; i++) if (bad < 0 && ram[i] !== exp_mem[i]) bad = i;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, req, ram[bad], exp_mem[bad]);
  endtask

  initial begin
    idle(3);
    // R9 reset state
    chk(busy == 0, "R9 busy in reset", busy, 0);
    chk(standby == 0, "R9 standby in reset", standby, 0);
    chk(arr_we == 0, "R9 arr_we in reset", arr_we, 0);
    rst = 0; idle(2);

    // R1 basic three-byte write
    cmd('h045, 1); sendb(8'hA1); sendb(8'hB2); sendb(8'hC3); csup(1);
    chk(busy == 1, "R4 busy after cs rise", busy, 1);
    idle(CYC + 4);
    chk(ram['h045] == 8'hA1, "R1 first byte", ram['h045], 8'hA1);
    chk(ram['h047] == 8'hC3, "R1 third byte", ram['h047], 8'hC3);
    chk(ram['h048] == init_val('h048), "R8 untouched neighbour", ram['h048], init_val('h048));
    mem_all("R8 array image");

    // R2 wrap inside page
    cmd('h07E, 1);
    for (int i = 0; i < 5; i++) sendb(8'(8'h10 + i));
    csup(1); idle(CYC + 4);
    chk(ram['h07F] == 8'h11, "R2 last offset", ram['h07F], 8'h11);
    chk(ram['h040] == 8'h12, "R2 wrapped to page start", ram['h040], 8'h12);
    chk(ram['h080] == init_val('h080), "R2 next page untouched", ram['h080], init_val('h080));
    mem_all("R2 array image");

    // R2 overrun of a full page
    cmd('h100, 1);
    for (int i = 0; i < 65; i++) sendb(8'(8'h80 + i));
    csup(1); idle(CYC + 4);
    chk(ram['h100] == 8'hC0, "R2 overwritten offset", ram['h100], 8'hC0);
    chk(ram['h13F] == 8'hBF, "R2 end of page", ram['h13F], 8'hBF);
    mem_all("R2 overrun image");

    // R3 no data bytes
    cmd('h200, 1); csup(1);
    chk(busy == 0, "R3 zero bytes", busy, 0);
    // R3 partial byte
    cmd('h200, 1); sendb(8'h11); sendb(8'h22); csup(0);
    chk(busy == 0, "R3 misaligned", busy, 0);
    idle(4);
    chk(ram['h200] == init_val('h200), "R3 array untouched", ram['h200], init_val('h200));

    // R6 not permitted
    cmd('h210, 0); sendb(8'h33); sendb(8'h44); csup(1);
    chk(busy == 0, "R6 no busy", busy, 0);
    idle(4);
    chk(ram['h210] == init_val('h210), "R6 array untouched", ram['h210], init_val('h210));
    mem_all("R6 array image");

    // R7 traffic during busy
    cmd('h300, 1); sendb(8'h55); csup(1);
    idle(3);
    cmd('h301, 1); sendb(8'h66); csup(1);
    idle(CYC + 4);
    chk(ram['h300] == 8'h55, "R7 original commit", ram['h300], 8'h55);
    chk(ram['h301] == init_val('h301), "R7 busy write ignored", ram['h301], init_val('h301));
    chk(busy == 0, "R7 no second interval", busy, 0);
    mem_all("R7 array image");

    // R5 standby follows chip select when idle
    chk(standby == 1, "R5 standby cs high", standby, 1);
    @(negedge clk); cs_high = 0; idle(2);
    chk(standby == 0, "R5 standby cs low", standby, 0);
    idle(2);
    summary();
  end
endmodule